// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is an 18-bit wide first-in first-out buffer. Its write port and its read port run on clocks that need not be related. The write side pushes a word on a write-clock edge when its active-low write enable is held LOW. The read side takes a word on a read-clock edge when its active-low read enable is held LOW. Five active-low status pins report the fill level: full, empty, more than half full, almost empty and almost full. The two "almost" thresholds sit in two offset registers. Software can load them through the write data bus, and read them back on the read data bus, while an active-low load strobe is held.

Back-pressure works through the flag pins and not through a handshake. A write that arrives while the buffer is full is dropped. A read strobe that arrives while nothing is stored is ignored, and the output keeps its last value. A static mode pin picks one of two read styles. In standard mode, a strobe pops the next word into the output register. In fall-through mode, the oldest word appears on the output without any strobe, and a strobe consumes it. In fall-through mode the full pin turns into a "space available" pin and the empty pin turns into a "data valid" pin, both active LOW. The depth is a parameter, and the reset value of both offsets is derived from it.

Top module: `dcf_fifo`

## Requirements
- R1: While `rst_n` is LOW, both pointers return to location zero, `afull_n` and `half_n` are HIGH and `aempty_n` is LOW. In standard mode `wr_flag_n` is HIGH and `rd_flag_n` is LOW.
- R2: A word is stored on a `wr_clk` rising edge when `wr_en_n` is LOW, `load_n` is HIGH and the buffer is not full. A write attempted while full is dropped.
- R3: In standard mode, a `rd_clk` rising edge with `rd_en_n` LOW, `load_n` HIGH and data stored loads the oldest word into `dout`. With `rd_en_n` HIGH, or with nothing stored, `dout` keeps its value. `rd_flag_n` is LOW when nothing is stored, and `wr_flag_n` is LOW when all DEPTH locations are used.
- R4: Words leave in the order they were written, with all 18 bits intact.
- R5: A `wr_clk` edge with `load_n` and `wr_en_n` both LOW stores `din[11:0]` in an offset register and writes no buffer word. The first such load after reset goes to the almost-empty offset, the next to the almost-full offset, and the order keeps alternating. `din[17:12]` is ignored.
- R6: A `rd_clk` edge with `load_n` and `rd_en_n` both LOW puts an offset on `dout[11:0]`, with `dout[17:12]` zero, and pops nothing. The order is almost-empty, then almost-full, alternating. In standard mode the value stays on `dout` until the next read strobe taken with `load_n` HIGH.
- R7: `aempty_n` is LOW exactly when the stored word count is at most the almost-empty offset.
- R8: `afull_n` is LOW exactly when the free space (DEPTH minus count) is at most the almost-full offset.
- R9: `half_n` is LOW exactly when the count exceeds DEPTH/2.
- R10: After reset, both offsets equal min(DEPTH/8 - 1, 127): 31 for 256, 63 for 512, and 127 for 1024 and deeper.
- R11: In fall-through mode, the oldest word appears on `dout` with no strobe and `rd_flag_n` goes LOW. A strobe with `load_n` HIGH consumes that word, and the next one takes its place. `rd_flag_n` returns HIGH when no word is left.
- R12: In fall-through mode, `wr_flag_n` is LOW while the storage array has a free location and HIGH when it is full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft_mode | input | 1 | Static: 0 = standard read, 1 = fall-through read |
| wr_en_n | input | 1 | Active-low write enable |
| load_n | input | 1 | Active-low strobe that steers both enables to the offset registers |
| din | input | 18 | Write data, or an offset value in bits 11:0 |
| wr_flag_n | output | 1 | Full (standard) or space-available (fall-through), active LOW |
| afull_n | output | 1 | Almost-full flag, active LOW |
| half_n | output | 1 | More-than-half-full flag, active LOW |
| rd_en_n | input | 1 | Active-low read enable |
| dout | output | 18 | Read data, or an offset value in bits 11:0 |
| rd_flag_n | output | 1 | Empty (standard) or data-valid (fall-through), active LOW |
| aempty_n | output | 1 | Almost-empty flag, active LOW |

## Verification
A corrupt write pointer or a lost Gray-coded update changes the count one side sees. This shows up as a threshold flag that moves at the wrong fill level a few clock edges after the write or read that should have moved it, or as a stale or extra word during the drain. A wrong offset-select state swaps the two offsets. That is visible at once in the readback order, and then in `aempty_n` and `afull_n` switching at the wrong counts. A fault in the fall-through head register shows within one read edge: `rd_flag_n` stays wrong, or `dout` skips or repeats a word. The checks compare each drained word and each flag level against counts worked out from the write and read history.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

  // Which offset register the next load or readback addresses.
  typedef enum logic {
    SEL_AE = 1'b0,
    SEL_AF = 1'b1
  } off_sel_e;

  // Reset offset: one eighth of the depth minus one, capped at 127.
  function automatic int dflt_off(input int depth);
    int v;
    v = depth / 8 - 1;
    if (v > 127) v = 127;
    if (v < 0) v = 0;
    return v;
  endfunction

endpackage

// File: rtl/dcf_sync.sv
// Two-stage synchronizer for a Gray-coded pointer.
module dcf_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/dcf_ram.sv
// Storage array: synchronous write, combinational read.
module dcf_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_ctl.sv
// Write-domain control: pointer, offset registers, full / almost-full / half flags.
module dcf_wr_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int OW    = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_i,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [OW-1:0] off_din,
  input  logic [CW-1:0] rgray_s,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [CW-1:0] wbin,
  output logic [CW-1:0] wgray,
  output logic [OW-1:0] ae_off,
  output logic [OW-1:0] af_off,
  output logic          wr_flag_n,
  output logic          afull_n,
  output logic          half_n
);
  localparam int XW   = ((OW > CW) ? OW : CW) + 1;
  localparam int DFLT = dflt_off(DEPTH);

  logic [CW-1:0] rbin_s;
  logic [CW-1:0] cnt;
  logic [CW-1:0] wbin_nx;
  logic          full;
  logic          off_wr;
  off_sel_e      wsel;

  // Gray to binary for the synchronized read pointer.
  always_comb begin
    rbin_s[CW-1] = rgray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
  end

  assign cnt     = wbin - rbin_s;
  assign full    = (cnt == CW'(DEPTH));
  assign we      = !wr_en_n && load_n && !full;
  assign off_wr  = !wr_en_n && !load_n;
  assign wbin_nx = wbin + CW'(1);
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (we) begin
      wbin  <= wbin_nx;
      wgray <= wbin_nx ^ (wbin_nx >> 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ae_off <= OW'(DFLT);
      af_off <= OW'(DFLT);
      wsel   <= SEL_AE;
    end else if (off_wr) begin
      if (wsel == SEL_AE) ae_off <= off_din;
      else                af_off <= off_din;
      wsel <= (wsel == SEL_AE) ? SEL_AF : SEL_AE;
    end
  end

  logic [XW-1:0] cnt_x;
  logic [XW-1:0] room_x;
  assign cnt_x  = XW'(cnt);
  assign room_x = cnt_x + XW'(af_off);

  assign wr_flag_n = fwft_i ? full : !full;
  assign afull_n   = !(room_x >= XW'(DEPTH));
  assign half_n    = !(cnt > CW'(DEPTH / 2));
endmodule

// File: rtl/dcf_rd_ctl.sv
// Read-domain control: pointer, output register, fall-through head, offset readback,
// empty / almost-empty flags.
module dcf_rd_ctl
  import dcf_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  parameter int OW    = 12,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft_i,
  input  logic          rd_en_n,
  input  logic          load_n,
  input  logic [CW-1:0] wgray_s,
  input  logic [OW-1:0] ae_off,
  input  logic [OW-1:0] af_off,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] rbin,
  output logic [CW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          rd_flag_n,
  output logic          aempty_n
);
  localparam int XW = ((OW > CW) ? OW : CW) + 1;

  logic [CW-1:0] wbin_s;
  logic [CW-1:0] mem_cnt;
  logic [CW-1:0] rbin_nx;
  logic          mem_empty;
  logic          pop, consume, fetch, adv, rb_req, rb_clr;
  logic [DW-1:0] q_r;
  logic          q_vld;
  logic [OW-1:0] rb_val;
  logic          rb_show;
  off_sel_e      rsel;

  always_comb begin
    wbin_s[CW-1] = wgray_s[CW-1];
    for (int i = CW - 2; i >= 0; i--) wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
  end

  assign mem_cnt   = wbin_s - rbin;
  assign mem_empty = (mem_cnt == '0);
  assign raddr     = rbin[AW-1:0];
  assign rbin_nx   = rbin + CW'(1);

  // Standard mode pops into the output register; fall-through keeps a head word.
  assign rb_req  = !rd_en_n && !load_n;
  assign pop     = !fwft_i && !rd_en_n && load_n && !mem_empty;
  assign consume = fwft_i && q_vld && !rd_en_n && load_n && !rb_show;
  assign fetch   = fwft_i && !mem_empty && (!q_vld || consume);
  assign adv     = pop || fetch;
  assign rb_clr  = load_n && (fwft_i || !rd_en_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
      q_r   <= '0;
    end else if (adv) begin
      rbin  <= rbin_nx;
      rgray <= rbin_nx ^ (rbin_nx >> 1);
      q_r   <= mem_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q_vld <= 1'b0;
    else if (fetch)   q_vld <= 1'b1;
    else if (consume) q_vld <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_val  <= '0;
      rb_show <= 1'b0;
      rsel    <= SEL_AE;
    end else if (rb_req) begin
      rb_val  <= (rsel == SEL_AE) ? ae_off : af_off;
      rb_show <= 1'b1;
      rsel    <= (rsel == SEL_AE) ? SEL_AF : SEL_AE;
    end else if (rb_clr) begin
      rb_show <= 1'b0;
    end
  end

  logic [XW-1:0] total;
  assign total = XW'(mem_cnt) + XW'(fwft_i && q_vld);

  assign dout      = rb_show ? DW'(rb_val) : q_r;
  assign rd_flag_n = fwft_i ? !q_vld : !mem_empty;
  assign aempty_n  = !(total <= XW'(ae_off));
endmodule

// File: rtl/dcf_fifo.sv
// Top: dual-clock FIFO with programmable threshold flags.
module dcf_fifo #(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  parameter int OW    = 12
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          fwft_mode,
  input  logic          wr_en_n,
  input  logic          load_n,
  input  logic [DW-1:0] din,
  output logic          wr_flag_n,
  output logic          afull_n,
  output logic          half_n,
  input  logic          rd_en_n,
  output logic [DW-1:0] dout,
  output logic          rd_flag_n,
  output logic          aempty_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] wr_bin, wr_gray, rd_bin, rd_gray;
  logic [CW-1:0] wr_gray_s, rd_gray_s;
  logic [OW-1:0] ae_off, af_off;
  logic [DW-1:0] mem_q;

  dcf_wr_ctl #(.DEPTH(DEPTH), .OW(OW)) wr_i (
    .clk      (wr_clk),
    .rst_n    (rst_n),
    .fwft_i   (fwft_mode),
    .wr_en_n  (wr_en_n),
    .load_n   (load_n),
    .off_din  (din[OW-1:0]),
    .rgray_s  (rd_gray_s),
    .we       (we),
    .waddr    (waddr),
    .wbin     (wr_bin),
    .wgray    (wr_gray),
    .ae_off   (ae_off),
    .af_off   (af_off),
    .wr_flag_n(wr_flag_n),
    .afull_n  (afull_n),
    .half_n   (half_n)
  );

  dcf_ram #(.DEPTH(DEPTH), .DW(DW)) ram_i (
    .wclk (wr_clk),
    .we   (we),
    .waddr(waddr),
    .wdata(din),
    .raddr(raddr),
    .rdata(mem_q)
  );

  dcf_sync #(.W(CW)) w2r_i (.clk(rd_clk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));
  dcf_sync #(.W(CW)) r2w_i (.clk(wr_clk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));

  dcf_rd_ctl #(.DEPTH(DEPTH), .DW(DW), .OW(OW)) rd_i (
    .clk      (rd_clk),
    .rst_n    (rst_n),
    .fwft_i   (fwft_mode),
    .rd_en_n  (rd_en_n),
    .load_n   (load_n),
    .wgray_s  (wr_gray_s),
    .ae_off   (ae_off),
    .af_off   (af_off),
    .mem_q    (mem_q),
    .raddr    (raddr),
    .rbin     (rd_bin),
    .rgray    (rd_gray),
    .dout     (dout),
    .rd_flag_n(rd_flag_n),
    .aempty_n (aempty_n)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
// Property checker, attached to the top by bind.
module dcf_fifo_chk #(
  parameter int DEPTH = 256,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          rst_n,
  input logic          fwft_mode,
  input logic          wr_en_n,
  input logic          rd_en_n,
  input logic          load_n,
  input logic          wr_flag_n,
  input logic          rd_flag_n,
  input logic          afull_n,
  input logic          aempty_n,
  input logic          half_n,
  input logic [CW-1:0] wbin,
  input logic [CW-1:0] rbin
);
  // R1: flag levels while reset is held
  a_r1_reset_wr_flags: assert property (@(posedge wr_clk) !rst_n |-> (afull_n && half_n));
  a_r1_reset_rd_flags: assert property (@(posedge rd_clk) !rst_n |-> !aempty_n);

  // R2: a write while full does not move the write pointer
  a_r2_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!fwft_mode && !wr_flag_n && !wr_en_n) |=> (wbin == $past(wbin)));

  // R3: a read while empty does not move the read pointer
  a_r3_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && !rd_flag_n && !rd_en_n && load_n) |=> (rbin == $past(rbin)));

  // R5: an offset load never stores a buffer word
  a_r5_load_no_push: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !load_n |=> (wbin == $past(wbin)));

  // R6: an offset readback never pops
  a_r6_readback_no_pop: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && !load_n && !rd_en_n) |=> (rbin == $past(rbin)));

  // R7: empty implies almost-empty
  a_r7_empty_in_ae: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!fwft_mode && !rd_flag_n) |-> !aempty_n);

  // R8: full implies almost-full
  a_r8_full_in_af: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!fwft_mode && !wr_flag_n) |-> !afull_n);

  // R9: full implies more than half full
  a_r9_full_in_half: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!fwft_mode && !wr_flag_n) |-> !half_n);
endmodule

bind dcf_fifo dcf_fifo_chk #(.DEPTH(DEPTH)) chk_i (
  .wr_clk   (wr_clk),
  .rd_clk   (rd_clk),
  .rst_n    (rst_n),
  .fwft_mode(fwft_mode),
  .wr_en_n  (wr_en_n),
  .rd_en_n  (rd_en_n),
  .load_n   (load_n),
  .wr_flag_n(wr_flag_n),
  .rd_flag_n(rd_flag_n),
  .afull_n  (afull_n),
  .aempty_n (aempty_n),
  .half_n   (half_n),
  .wbin     (wr_bin),
  .rbin     (rd_bin)
);

// File: tb/dcf_fifo_tb_top.sv
`timescale 1ns/1ps
module dcf_fifo_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        fwft_mode = 1'b0;
  logic        wr_en_n = 1'b1;
  logic        rd_en_n = 1'b1;
  logic        load_n = 1'b1;
  logic [17:0] din = '0;
  logic        wr_flag_n, afull_n, half_n, rd_flag_n, aempty_n;
  logic [17:0] dout;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  dcf_fifo #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en_n(wr_en_n), .load_n(load_n), .din(din),
    .wr_flag_n(wr_flag_n), .afull_n(afull_n), .half_n(half_n),
    .rd_en_n(rd_en_n), .dout(dout), .rd_flag_n(rd_flag_n), .aempty_n(aempty_n)
  );

  // Word and expected flags after writing it (default offsets of 1, depth 16).
  typedef struct packed {
    logic [17:0] d;
    logic        ae;
    logic        hf;
    logic        af;
    logic        ff;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{18'h00001, 1'b0, 1'b1, 1'b1, 1'b1},
    '{18'h3FFFF, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h2AAAA, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h15555, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h00000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h20000, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h1F0F0, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h0C3C3, 1'b1, 1'b1, 1'b1, 1'b1},
    '{18'h12345, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h3ABCD, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h00F00, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h3C00F, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h11111, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h2DEAD, 1'b1, 1'b0, 1'b1, 1'b1},
    '{18'h1BEEF, 1'b1, 1'b0, 1'b0, 1'b1},
    '{18'h05A5A, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic do_write(input logic [17:0] d);
    @(negedge clk); din = d; wr_en_n = 1'b0;
    @(posedge clk); @(negedge clk); wr_en_n = 1'b1;
    settle();
  endtask

  task automatic do_read();
    @(negedge clk); rd_en_n = 1'b0;
    @(posedge clk); @(negedge clk); rd_en_n = 1'b1;
    settle();
  endtask

  task automatic do_load(input logic [17:0] d);
    @(negedge clk); din = d; load_n = 1'b0; wr_en_n = 1'b0;
    @(posedge clk); @(negedge clk); load_n = 1'b1; wr_en_n = 1'b1;
    settle();
  endtask

  task automatic do_readback();
    @(negedge clk); load_n = 1'b0; rd_en_n = 1'b0;
    @(posedge clk); @(negedge clk); load_n = 1'b1; rd_en_n = 1'b1;
    settle();
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk); rst_n = 1'b0; fwft_mode = mode;
    repeat (3) @(negedge clk); rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: levels during reset
    chk("R1 wr_flag_n", wr_flag_n, 1); chk("R1 afull_n", afull_n, 1);
    chk("R1 half_n", half_n, 1);       chk("R1 rd_flag_n", rd_flag_n, 0);
    chk("R1 aempty_n", aempty_n, 0);
    rst_n = 1'b1;
    settle();

    // R10: default offsets read back in order (DEPTH 16 -> 1)
    do_readback(); chk("R10 default ae offset", dout, 18'h1);
    do_readback(); chk("R10 default af offset", dout, 18'h1);

    // Table: fill to full, checking thresholds after every word (R2 R7 R8 R9)
    for (int i = 0; i < 16; i++) begin
      do_write(VEC[i].d);
      chk("R7 aempty_n vs count", aempty_n, VEC[i].ae);
      chk("R9 half_n vs count", half_n, VEC[i].hf);
      chk("R8 afull_n vs count", afull_n, VEC[i].af);
      chk("R3 wr_flag_n full", wr_flag_n, VEC[i].ff);
      chk("R2 not empty", rd_flag_n, 1);
    end

    // R2: write while full is dropped
    do_write(18'h2FFFF);
    chk("R2 still full", wr_flag_n, 0);

    // R4 R3: drain in order; dout held between strobes
    for (int i = 0; i < 16; i++) begin
      do_read();
      chk("R4 order and data", dout, VEC[i].d);
      @(negedge clk);
      chk("R3 dout held", dout, VEC[i].d);
    end
    chk("R2 dropped word absent (empty)", rd_flag_n, 0);
    chk("R3 full released", wr_flag_n, 1);

    // R3: read while empty keeps dout
    do_read();
    chk("R3 read on empty holds dout", dout, VEC[15].d);

    // R5: load offsets in order, upper bits ignored, no word stored
    do_load(18'h00003);
    do_load(18'h3F004);
    chk("R5 load stores no word", rd_flag_n, 0);
    chk("R5 load no half", half_n, 1);
    // R6: readback order, upper bits zero, no pop
    do_readback(); chk("R6 readback ae", dout, 18'h3);
    do_readback(); chk("R6 readback af", dout, 18'h4);
    chk("R6 readback no pop", rd_flag_n, 0);

    // R7 R8 R9 with ae=3, af=4 (afull when count >= 12)
    for (int c = 1; c <= 12; c++) begin
      do_write(18'(c));
      if (c == 3)  chk("R7 ae at count 3", aempty_n, 0);
      if (c == 4)  chk("R7 ae at count 4", aempty_n, 1);
      if (c == 8)  chk("R9 half at count 8", half_n, 1);
      if (c == 9)  chk("R9 half at count 9", half_n, 0);
      if (c == 11) chk("R8 af at count 11", afull_n, 1);
      if (c == 12) chk("R8 af at count 12", afull_n, 0);
    end

    // Fall-through mode
    do_reset(1'b1);
    chk("R11 no data valid", rd_flag_n, 1);
    chk("R12 space available", wr_flag_n, 0);
    chk("R1 aempty after reset", aempty_n, 0);
    do_write(18'h0A001);
    chk("R11 head without strobe", dout, 18'h0A001);
    chk("R11 data valid", rd_flag_n, 0);
    do_write(18'h0A002);
    do_read();
    chk("R11 next word after strobe", dout, 18'h0A002);
    chk("R11 still valid", rd_flag_n, 0);
    do_read();
    chk("R11 drained", rd_flag_n, 1);

    for (int i = 0; i < 17; i++) begin
      do_write(18'h10000 + 18'(i));
      if (i == 15) chk("R12 space with 15 stored", wr_flag_n, 0);
      if (i == 16) chk("R12 array full", wr_flag_n, 1);
    end
    chk("R11 head is first", dout, 18'h10000);
    do_read();
    chk("R11 head advanced", dout, 18'h10001);
    chk("R12 space after read", wr_flag_n, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule